// File: doc/BRIEF.md
# ADC Conversion Results Buffer with Read Formatting

This block holds the results of one group of analog-to-digital conversions. A conversion engine pushes entries, each a 12-bit result together with the 5-bit number of the analog input it came from. A bus reader drains the entries in arrival order through a FIFO-style read port. It can also look at any slot directly by address.

On the FIFO port the result can be delivered at full 12-bit width or cut down to its top 10 or top 8 bits. The input number can be placed in a tag field or forced to zero. When the buffer is full, one of two overrun policies applies. In the stalling policy, new results are refused until the reader has emptied the buffer. In the restart policy, writing begins again at slot 0.

A write of a non-zero channel selection clears the buffer. A keep-contents mode bit can suppress this clear, but only while the conversion group is idle.

Top module: `adc_result_buf`

## Requirements
- R1: After reset the buffer is empty, `fifo_data` reads 0, `ovr_flag` is 0 and every slot reads 0 through `ram_data`.
- R2: Entries leave the FIFO port in the order they were written, and each `fifo_rd` pulse on a non-empty buffer advances to the next entry.
- R3: With `cfg_fmt` 0 or 3, `fifo_data[11:0]` holds the full result and `fifo_data[20:16]` holds the input number when `cfg_chid_en` is 1. All other bits are 0.
- R4: With `cfg_fmt` 1, `fifo_data[9:0]` holds result bits 11..2.
- R5: With `cfg_fmt` 2, `fifo_data[7:0]` holds result bits 11..4. In both narrow formats (`cfg_fmt` 1 and 2), `fifo_data[14:10]` holds the input number when `cfg_chid_en` is 1, and all other bits are 0.
- R6: With `cfg_chid_en` 0, the tag field of the active format reads 0.
- R7: `ram_data` at `ram_addr` returns {input number[16:12], result[11:0]} of that slot, whatever `cfg_chid_en` holds.
- R8: A `sel_wr` pulse with a non-zero `sel_value` while `cfg_no_reset` is 0 empties the buffer, zeroes every slot and clears `ovr_flag`.
- R9: A `sel_wr` pulse with a zero `sel_value` never clears. A non-zero one leaves the contents intact while `cfg_no_reset` is 1 and `grp_busy` is 0.
- R10: While `grp_busy` is 1, a `sel_wr` pulse with a non-zero `sel_value` clears the buffer even when `cfg_no_reset` is 1.
- R11: With `cfg_ovr_wrap` 0, a write into a full buffer is dropped and sets `ovr_flag`. Every later write is dropped until reads have emptied the buffer. The stored count never exceeds the depth.
- R12: With `cfg_ovr_wrap` 1, a write into a full buffer is stored in slot 0 and sets `ovr_flag`. The FIFO then holds only that entry, and later writes continue from slot 1.
- R13: A `fifo_rd` on an empty buffer returns 0 on `fifo_data` and leaves the read position unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Conversion engine delivers a result this cycle |
| wr_result | input | 12 | Conversion result |
| wr_chan | input | 5 | Analog input number of the result |
| sel_wr | input | 1 | Channel selection is written this cycle |
| sel_value | input | SEL_W | Written channel selection (one bit per input) |
| grp_busy | input | 1 | Group conversions active or frozen |
| cfg_no_reset | input | 1 | Keep contents on selection write while idle |
| cfg_fmt | input | 2 | FIFO read format: 0/3 full, 1 ten-bit, 2 eight-bit |
| cfg_chid_en | input | 1 | Insert input number into the FIFO word |
| cfg_ovr_wrap | input | 1 | Overrun policy: 0 stall, 1 restart at slot 0 |
| fifo_rd | input | 1 | Pop the oldest entry |
| fifo_data | output | 32 | Formatted oldest entry, 0 when empty |
| ram_addr | input | log2(DEPTH) | Direct read slot address |
| ram_data | output | 17 | Raw slot content {input number, result} |
| ovr_flag | output | 1 | Overrun has occurred since the last clear |

## Verification
The bench builds the buffer with DEPTH set to 4 and SEL_W left at 16. A shallow buffer makes the full condition reachable after four writes. This brings both overrun policies into reach within a few cycles: the stall, the drain that releases it, and the restart at slot 0 followed by a write at slot 1. The direct read port can also be swept over every slot to confirm clears and the restart position.

// File: rtl/adc_rbuf_pkg.sv
package adc_rbuf_pkg;
  localparam int RES_W         = 12;
  localparam int CH_W          = 5;
  localparam int WORD_W        = 32;
  localparam int NARROW_TAG_LO = 10;
  localparam int FULL_TAG_LO   = 16;
  localparam int SHIFT_W10     = 2;
  localparam int SHIFT_W8      = 4;
  localparam int ENTRY_W       = RES_W + CH_W;

  typedef enum logic [1:0] {
    FMT_FULL = 2'd0,
    FMT_W10  = 2'd1,
    FMT_W8   = 2'd2,
    FMT_ALT  = 2'd3
  } fmt_e;

  typedef struct packed {
    logic [CH_W-1:0]  chan;
    logic [RES_W-1:0] res;
  } entry_t;
endpackage

// File: rtl/adc_rbuf_ctrl.sv
module adc_rbuf_ctrl #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_valid,
  input  logic          rd_req,
  input  logic          wrap_mode,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_ptr,
  output logic [AW:0]   level,
  output logic          empty,
  output logic          blocked,
  output logic          ovr_flag
);
  localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic          ovr_q, ovr_d, blk_q, blk_d;
  logic          full, rd_fire, wr_ok, wrap_ev, blk_ev;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    full    = (cnt_q == FULL_CNT);
    empty   = (cnt_q == '0);
    rd_fire = rd_req && !empty;
    wr_ok   = wr_valid && !full && !blk_q;
    wrap_ev = wr_valid && full && !blk_q && wrap_mode;
    blk_ev  = wr_valid && full && !blk_q && !wrap_mode;

    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    ovr_d    = ovr_q;
    blk_d    = blk_q;

    if (clr) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
      ovr_d    = 1'b0;
      blk_d    = 1'b0;
    end else if (wrap_ev) begin
      wr_ptr_d = bump('0);
      rd_ptr_d = '0;
      cnt_d    = (AW+1)'(1);
      ovr_d    = 1'b1;
    end else begin
      if (wr_ok)   wr_ptr_d = bump(wr_ptr_q);
      if (rd_fire) rd_ptr_d = bump(rd_ptr_q);
      cnt_d = cnt_q + (AW+1)'(wr_ok) - (AW+1)'(rd_fire);
      if (blk_ev) begin
        blk_d = 1'b1;
        ovr_d = 1'b1;
      end else if (cnt_d == '0) begin
        blk_d = 1'b0;
      end
    end

    wr_en   = !clr && (wr_ok || wrap_ev);
    wr_addr = wrap_ev ? '0 : wr_ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovr_q    <= 1'b0;
      blk_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
      ovr_q    <= ovr_d;
      blk_q    <= blk_d;
    end
  end

  assign rd_ptr   = rd_ptr_q;
  assign level    = cnt_q;
  assign blocked  = blk_q;
  assign ovr_flag = ovr_q;
endmodule

// File: rtl/adc_rbuf_mem.sv
module adc_rbuf_mem
  import adc_rbuf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  entry_t        wr_entry,
  input  logic [AW-1:0] head_addr,
  output entry_t        head_entry,
  input  logic [AW-1:0] peek_addr,
  output entry_t        peek_entry
);
  localparam logic [AW:0] SLOTS = (AW+1)'(DEPTH);

  entry_t slot_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic   hit;
    entry_t slot_d;

    always_comb begin
      hit    = wr_en && (wr_addr == AW'(i));
      slot_d = slot_q[i];
      if (clr)      slot_d = '0;
      else if (hit) slot_d = wr_entry;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          slot_q[i] <= '0;
      else if (clr || hit) slot_q[i] <= slot_d;
    end
  end

  always_comb begin
    head_entry = ({1'b0, head_addr} < SLOTS) ? slot_q[head_addr] : '0;
    peek_entry = ({1'b0, peek_addr} < SLOTS) ? slot_q[peek_addr] : '0;
  end
endmodule

// File: rtl/adc_rbuf_fmt.sv
module adc_rbuf_fmt
  import adc_rbuf_pkg::*;
(
  input  entry_t            head,
  input  logic              empty,
  input  fmt_e              fmt,
  input  logic              chid_en,
  output logic [WORD_W-1:0] word
);
  always_comb begin
    word = '0;
    if (!empty) begin
      case (fmt)
        FMT_W10: begin
          word[RES_W-SHIFT_W10-1:0] = head.res[RES_W-1:SHIFT_W10];
          if (chid_en) word[NARROW_TAG_LO +: CH_W] = head.chan;
        end
        FMT_W8: begin
          word[RES_W-SHIFT_W8-1:0] = head.res[RES_W-1:SHIFT_W8];
          if (chid_en) word[NARROW_TAG_LO +: CH_W] = head.chan;
        end
        default: begin
          word[RES_W-1:0] = head.res;
          if (chid_en) word[FULL_TAG_LO +: CH_W] = head.chan;
        end
      endcase
    end
  end
endmodule

// File: rtl/adc_result_buf.sv
module adc_result_buf
  import adc_rbuf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int SEL_W = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  input  logic [RES_W-1:0]    wr_result,
  input  logic [CH_W-1:0]     wr_chan,
  input  logic                sel_wr,
  input  logic [SEL_W-1:0]    sel_value,
  input  logic                grp_busy,
  input  logic                cfg_no_reset,
  input  logic [1:0]          cfg_fmt,
  input  logic                cfg_chid_en,
  input  logic                cfg_ovr_wrap,
  input  logic                fifo_rd,
  output logic [WORD_W-1:0]   fifo_data,
  input  logic [AW-1:0]       ram_addr,
  output logic [ENTRY_W-1:0]  ram_data,
  output logic                ovr_flag
);
  logic          clr_w, wr_en_w, empty_w, blk_w;
  logic [AW-1:0] wr_addr_w, rd_ptr_w;
  logic [AW:0]   lvl_w;
  entry_t        new_entry, head_entry, peek_entry;

  assign clr_w     = sel_wr && (|sel_value) && (!cfg_no_reset || grp_busy);
  assign new_entry = '{chan: wr_chan, res: wr_result};

  adc_rbuf_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr_w),
    .wr_valid  (wr_valid),
    .rd_req    (fifo_rd),
    .wrap_mode (cfg_ovr_wrap),
    .wr_en     (wr_en_w),
    .wr_addr   (wr_addr_w),
    .rd_ptr    (rd_ptr_w),
    .level     (lvl_w),
    .empty     (empty_w),
    .blocked   (blk_w),
    .ovr_flag  (ovr_flag)
  );

  adc_rbuf_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr_w),
    .wr_en      (wr_en_w),
    .wr_addr    (wr_addr_w),
    .wr_entry   (new_entry),
    .head_addr  (rd_ptr_w),
    .head_entry (head_entry),
    .peek_addr  (ram_addr),
    .peek_entry (peek_entry)
  );

  adc_rbuf_fmt u_fmt (
    .head    (head_entry),
    .empty   (empty_w),
    .fmt     (fmt_e'(cfg_fmt)),
    .chid_en (cfg_chid_en),
    .word    (fifo_data)
  );

  assign ram_data = peek_entry;
endmodule

// File: rtl/adc_rbuf_chk.sv
module adc_rbuf_chk
  import adc_rbuf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int SEL_W = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              fifo_rd,
  input logic              sel_wr,
  input logic [SEL_W-1:0]  sel_value,
  input logic              grp_busy,
  input logic              cfg_no_reset,
  input logic [1:0]        cfg_fmt,
  input logic              cfg_chid_en,
  input logic              cfg_ovr_wrap,
  input logic [WORD_W-1:0] fifo_data,
  input logic              ovr_flag,
  input logic [AW:0]       level,
  input logic              empty,
  input logic              blocked
);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    level <= FULL_CNT);

  p_block_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ovr_wrap && wr_valid && level == FULL_CNT && !fifo_rd && !sel_wr
    |=> level == FULL_CNT && ovr_flag);

  p_wrap_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ovr_wrap && wr_valid && level == FULL_CNT && !blocked && !sel_wr
    |=> level == (AW+1)'(1) && ovr_flag);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr && (|sel_value) && !cfg_no_reset |=> level == '0 && !ovr_flag);

  p_busy_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr && (|sel_value) && grp_busy |=> level == '0);

  p_zero_sel_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr && sel_value == '0 && !wr_valid && !fifo_rd |=> $stable(level));

  p_empty_word_r13: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> fifo_data == '0);

  p_empty_pop_r13: assert property (@(posedge clk) disable iff (!rst_n)
    empty && fifo_rd && !wr_valid |=> empty);

  p_narrow_tag_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_chid_en && (cfg_fmt == 2'd1 || cfg_fmt == 2'd2) |-> fifo_data[14:10] == '0);

  p_full_tag_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_chid_en && (cfg_fmt == 2'd0 || cfg_fmt == 2'd3) |-> fifo_data[20:16] == '0);

  p_eight_bit_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_fmt == 2'd2 |-> fifo_data[9:8] == '0 && fifo_data[31:15] == '0);
endmodule

bind adc_result_buf adc_rbuf_chk #(.DEPTH(DEPTH), .SEL_W(SEL_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_valid     (wr_valid),
  .fifo_rd      (fifo_rd),
  .sel_wr       (sel_wr),
  .sel_value    (sel_value),
  .grp_busy     (grp_busy),
  .cfg_no_reset (cfg_no_reset),
  .cfg_fmt      (cfg_fmt),
  .cfg_chid_en  (cfg_chid_en),
  .cfg_ovr_wrap (cfg_ovr_wrap),
  .fifo_data    (fifo_data),
  .ovr_flag     (ovr_flag),
  .level        (lvl_w),
  .empty        (empty_w),
  .blocked      (blk_w)
);

// File: tb/adc_result_buf_bench.sv
module adc_result_buf_bench;
  localparam int DEPTH = 4;
  localparam int SEL_W = 16;
  localparam int AW    = $clog2(DEPTH);

  logic              clk;
  logic              rst_n;
  logic              wr_valid;
  logic [11:0]       wr_result;
  logic [4:0]        wr_chan;
  logic              sel_wr;
  logic [SEL_W-1:0]  sel_value;
  logic              grp_busy;
  logic              cfg_no_reset;
  logic [1:0]        cfg_fmt;
  logic              cfg_chid_en;
  logic              cfg_ovr_wrap;
  logic              fifo_rd;
  logic [31:0]       fifo_data;
  logic [AW-1:0]     ram_addr;
  logic [16:0]       ram_data;
  logic              ovr_flag;

  int n_chk;
  int n_bad;
  bit done;

  adc_result_buf #(.DEPTH(DEPTH), .SEL_W(SEL_W)) u_adc_result_buf (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_result(wr_result),
    .wr_chan(wr_chan), .sel_wr(sel_wr), .sel_value(sel_value),
    .grp_busy(grp_busy), .cfg_no_reset(cfg_no_reset), .cfg_fmt(cfg_fmt),
    .cfg_chid_en(cfg_chid_en), .cfg_ovr_wrap(cfg_ovr_wrap), .fifo_rd(fifo_rd),
    .fifo_data(fifo_data), .ram_addr(ram_addr), .ram_data(ram_data),
    .ovr_flag(ovr_flag)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, got, exp);
    end
  endtask

  function automatic logic [31:0] w_full(input logic [4:0] ch, input logic [11:0] r);
    return {11'd0, ch, 4'd0, r};
  endfunction

  function automatic logic [31:0] raw(input logic [4:0] ch, input logic [11:0] r);
    return {15'd0, ch, r};
  endfunction

  task automatic push(input logic [11:0] r, input logic [4:0] ch);
    wr_valid = 1'b1; wr_result = r; wr_chan = ch;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic pop();
    fifo_rd = 1'b1;
    @(negedge clk);
    fifo_rd = 1'b0;
  endtask

  task automatic sel_write(input logic [SEL_W-1:0] v);
    sel_wr = 1'b1; sel_value = v;
    @(negedge clk);
    sel_wr = 1'b0; sel_value = '0;
  endtask

  task automatic peek_raw(input string rq, input logic [AW-1:0] a, input logic [31:0] exp);
    ram_addr = a;
    #1;
    chk(rq, {15'd0, ram_data}, exp);
  endtask

  task automatic t_reset();
    chk("R1 fifo word", fifo_data, 32'd0);
    chk("R1 overrun flag", {31'd0, ovr_flag}, 32'd0);
    for (int i = 0; i < DEPTH; i++) peek_raw("R1 slot", AW'(i), 32'd0);
  endtask

  task automatic t_order_full();
    push(12'hABC, 5'd3);
    push(12'h123, 5'd17);
    push(12'hFFF, 5'd31);
    chk("R2 R3 first", fifo_data, w_full(5'd3, 12'hABC));
    pop();
    chk("R2 second", fifo_data, w_full(5'd17, 12'h123));
    pop();
    cfg_fmt = 2'd3; #1;
    chk("R3 fmt3 full", fifo_data, w_full(5'd31, 12'hFFF));
    pop();
    cfg_fmt = 2'd0;
  endtask

  task automatic t_formats();
    push(12'hABC, 5'd9);
    cfg_fmt = 2'd1; #1;
    chk("R4 ten-bit tagged", fifo_data, 32'h0000_0000 | (32'd9 << 10) | 32'h2AF);
    cfg_fmt = 2'd2; #1;
    chk("R5 eight-bit tagged", fifo_data, (32'd9 << 10) | 32'hAB);
    cfg_chid_en = 1'b0; #1;
    chk("R6 eight-bit untagged", fifo_data, 32'h0AB);
    cfg_fmt = 2'd1; #1;
    chk("R6 ten-bit untagged", fifo_data, 32'h2AF);
    cfg_fmt = 2'd0; #1;
    chk("R6 full untagged", fifo_data, 32'hABC);
    cfg_chid_en = 1'b1;
    pop();
  endtask

  task automatic t_empty();
    chk("R13 empty word", fifo_data, 32'd0);
    pop();
    chk("R13 empty pop word", fifo_data, 32'd0);
    push(12'h055, 5'd1);
    chk("R13 pointer held", fifo_data, w_full(5'd1, 12'h055));
    pop();
  endtask

  task automatic t_clear();
    push(12'h111, 5'd2);
    push(12'h222, 5'd4);
    sel_write(16'h0001);
    chk("R8 cleared word", fifo_data, 32'd0);
    for (int i = 0; i < DEPTH; i++) peek_raw("R8 slot zero", AW'(i), 32'd0);
    push(12'h333, 5'd5);
    push(12'h444, 5'd6);
    cfg_chid_en = 1'b0;
    peek_raw("R7 slot0 raw", AW'(0), raw(5'd5, 12'h333));
    peek_raw("R7 slot1 raw", AW'(1), raw(5'd6, 12'h444));
    cfg_chid_en = 1'b1;
  endtask

  task automatic t_select();
    cfg_no_reset = 1'b1; grp_busy = 1'b0;
    sel_write(16'h0020);
    chk("R9 kept idle", fifo_data, w_full(5'd5, 12'h333));
    cfg_no_reset = 1'b0;
    sel_write(16'h0000);
    chk("R9 zero select kept", fifo_data, w_full(5'd5, 12'h333));
    cfg_no_reset = 1'b1; grp_busy = 1'b1;
    sel_write(16'h8000);
    chk("R10 busy clear word", fifo_data, 32'd0);
    peek_raw("R10 busy clear slot", AW'(0), 32'd0);
    cfg_no_reset = 1'b0; grp_busy = 1'b0;
  endtask

  task automatic t_block();
    cfg_ovr_wrap = 1'b0;
    for (int i = 0; i < DEPTH; i++) push(12'h100 + 12'(i), 5'(i));
    chk("R11 no overrun yet", {31'd0, ovr_flag}, 32'd0);
    push(12'hEEE, 5'd7);
    chk("R11 overrun flag", {31'd0, ovr_flag}, 32'd1);
    chk("R11 head kept", fifo_data, w_full(5'd0, 12'h100));
    pop();
    push(12'hDDD, 5'd8);
    for (int i = 1; i < DEPTH; i++) begin
      chk("R11 drain order", fifo_data, w_full(5'(i), 12'h100 + 12'(i)));
      pop();
    end
    chk("R11 blocked write dropped", fifo_data, 32'd0);
    push(12'hCCC, 5'd9);
    chk("R11 accepted after drain", fifo_data, w_full(5'd9, 12'hCCC));
    sel_write(16'h0001);
    chk("R8 clear drops flag", {31'd0, ovr_flag}, 32'd0);
  endtask

  task automatic t_wrap();
    cfg_ovr_wrap = 1'b1;
    for (int i = 0; i < DEPTH; i++) push(12'h200 + 12'(i), 5'(10 + i));
    push(12'h2AB, 5'd20);
    chk("R12 overrun flag", {31'd0, ovr_flag}, 32'd1);
    chk("R12 head is new", fifo_data, w_full(5'd20, 12'h2AB));
    peek_raw("R12 slot0 rewritten", AW'(0), raw(5'd20, 12'h2AB));
    peek_raw("R12 slot1 untouched", AW'(1), raw(5'd11, 12'h201));
    pop();
    chk("R12 single entry", fifo_data, 32'd0);
    push(12'h2CD, 5'd21);
    peek_raw("R12 next at slot1", AW'(1), raw(5'd21, 12'h2CD));
    chk("R12 next head", fifo_data, w_full(5'd21, 12'h2CD));
    cfg_ovr_wrap = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; wr_valid = 1'b0; wr_result = '0; wr_chan = '0;
    sel_wr = 1'b0; sel_value = '0; grp_busy = 1'b0; cfg_no_reset = 1'b0;
    cfg_fmt = 2'd0; cfg_chid_en = 1'b1; cfg_ovr_wrap = 1'b0;
    fifo_rd = 1'b0; ram_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order_full();
    t_formats();
    t_empty();
    t_clear();
    t_select();
    t_block();
    t_wrap();
    finish_run();
  end
endmodule